// File: doc/BRIEF.md
# Processor External Interrupt Collector

This block collects every interrupt source that feeds a processor core and turns them into three results. The first is a vector of pending bits, laid out for the core's cause register. The second is one maskable request line. The third is a single-cycle non-maskable event.

The sources are:
- six active-low request pins, captured on the system clock;
- a seven-bit internal interrupt register that the system bus can write but never read;
- an equality flag from an external count/compare pair;
- an active-low non-maskable pin.

Bus transfers take two cycles. An address cycle selects the target, and the data cycle that follows carries the payload. When the selected target is the interrupt register, the data word holds a write enable and a new value for each register bit, so one transfer can set some bits and clear others. Pending bit 5 can come from the timer comparison or from the ordinary sources; a boot-time disable input makes the choice. Register bit 6 is not a pending bit. It merges with the non-maskable pin, and the block reports only the moment that merged signal becomes active.

Top module: `irq_collector`

## Requirements
- R1: An address cycle (`sys_valid`=1, `sys_cmd`=1) with `sys_wr`=1 selects the interrupt register exactly when `sys_data[6:4]` is 3'b000, whatever the other address bits are. With any other value in those bits, the following data cycle leaves the register unchanged.
- R2: In the data cycle (`sys_valid`=1, `sys_cmd`=0) after a selecting address cycle, `sys_data[16+i]` enables register bit i and `sys_data[i]` is its new value, for i = 0..6. Bits whose enable is 0 keep their value. The new value is visible on the outputs in the cycle after that edge.
- R3: A data cycle has no effect on the register unless a selecting write address cycle preceded it. A read address cycle (`sys_wr`=0) therefore never leads to a register update.
- R4: Each `int_n[i]` is captured on the rising clock edge. `pending[i]` is 1 in the cycle after an edge at which `int_n[i]` was 0, or whenever register bit i is 1. The default is a single capture stage.
- R5: When `timer_dis`=0, `pending[5]` follows `timer_eq` directly, and both `int_n[5]` and register bit 5 are ignored. When `timer_dis`=1, `pending[5]` obeys R4 and `timer_eq` is ignored.
- R6: `irq_req` = `irq_en` AND (OR over i of `pending[i]` AND `irq_mask[i]`).
- R7: The non-maskable signal is register bit 6 OR the captured, inverted `nmi_n`. When that signal goes from inactive to active, `nmi_pulse` is 1 for exactly one cycle. It stays 0 while the signal remains active.
- R8: Reset (`rst_n`=0) clears the interrupt register, the captured pins and the non-maskable history. While reset is held, `pending`, `irq_req` and `nmi_pulse` are 0, even if the pins are asserted.
- R9: Register bit 6 never appears in `pending`. Setting it through the bus produces one `nmi_pulse`. While it stays set, a falling `nmi_n` produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_valid | input | 1 | Bus cycle present this clock |
| sys_cmd | input | 1 | 1 = address cycle, 0 = data cycle |
| sys_wr | input | 1 | Address cycle is a write |
| sys_data | input | 32 | Multiplexed address/data word |
| int_n | input | 6 | Active-low interrupt request pins |
| nmi_n | input | 1 | Active-low non-maskable pin |
| timer_eq | input | 1 | Count equals compare flag |
| timer_dis | input | 1 | Boot-mode timer source disable |
| irq_mask | input | 6 | Per-bit enable for the maskable request |
| irq_en | input | 1 | Global maskable interrupt enable |
| pending | output | 6 | Pending bits toward the cause register |
| irq_req | output | 1 | Combined maskable request |
| nmi_pulse | output | 1 | One-cycle non-maskable event |

## Verification
The assertions assume that bus cycles are well formed. A data cycle carries meaningful content only when an address cycle precedes it, and `sys_data` is stable around each sampling edge. They also assume `timer_eq` is a clean level that settles before the edge.

The stimulus drives every input on the falling clock edge. Each register write is issued as one address cycle followed directly by one data cycle. Orphan data cycles and read addresses are applied on purpose, to show that they are ignored. The non-maskable pin and the request pins are held for whole cycles, so each capture sees one settled value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Classification of one clock of the multiplexed system bus
   typedef enum logic [1:0] {
      BUS_IDLE = 2'd0,
      BUS_ADDR = 2'd1,
      BUS_DATA = 2'd2
   } bus_cyc_e;

   function automatic bus_cyc_e classify_cycle(input logic valid, input logic cmd);
      if (!valid)  return BUS_IDLE;
      else if (cmd) return BUS_ADDR;
      else          return BUS_DATA;
   endfunction

endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode #(
   parameter int DATA_W   = 32,
   parameter int SEL_LSB  = 4,
   parameter int SEL_W    = 3,
   parameter int EN_LSB   = 16,
   parameter int REG_BITS = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sys_valid,
   input  logic                sys_cmd,
   input  logic                sys_wr,
   input  logic [DATA_W-1:0]   sys_data,
   output logic                wr_stb,
   output logic [REG_BITS-1:0] wr_mask,
   output logic [REG_BITS-1:0] wr_val
);
   import irqc_pkg::*;

   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;
   localparam int EN_MSB  = EN_LSB + REG_BITS - 1;

   if (SEL_MSB >= DATA_W) begin : g_bad_sel
      $error("irqc_bus_decode: select field exceeds data width");
   end
   if (EN_MSB >= DATA_W) begin : g_bad_en
      $error("irqc_bus_decode: enable field exceeds data width");
   end
   if (REG_BITS > EN_LSB) begin : g_bad_overlap
      $error("irqc_bus_decode: value field overlaps enable field");
   end

   bus_cyc_e cyc;
   logic     sel_hit;
   logic     armed_q;

   assign cyc     = classify_cycle(sys_valid, sys_cmd);
   assign sel_hit = (sys_data[SEL_MSB:SEL_LSB] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else begin
         unique case (cyc)
            BUS_ADDR: armed_q <= sys_wr & sel_hit;
            BUS_DATA: armed_q <= 1'b0;
            default:  armed_q <= armed_q;
         endcase
      end
   end

   assign wr_stb  = (cyc == BUS_DATA) & armed_q;
   assign wr_mask = sys_data[EN_MSB:EN_LSB];
   assign wr_val  = sys_data[REG_BITS-1:0];

   // Address bits outside the select field play no part in decoding
   logic data_unused;
   assign data_unused = ^sys_data;

endmodule

// File: rtl/irqc_int_reg.sv
module irqc_int_reg #(
   parameter int REG_BITS = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_stb,
   input  logic [REG_BITS-1:0] wr_mask,
   input  logic [REG_BITS-1:0] wr_val,
   output logic [REG_BITS-1:0] q
);

   if (REG_BITS < 2) begin : g_bad_bits
      $error("irqc_int_reg: need at least one pending bit plus the NMI bit");
   end

   for (genvar i = 0; i < REG_BITS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[i] <= 1'b0;
         end else if (wr_stb && wr_mask[i]) begin
            q[i] <= wr_val[i];
         end
      end
   end

endmodule

// File: rtl/irqc_pin_sync.sv
module irqc_pin_sync #(
   parameter int W      = 6,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins_n,
   output logic [W-1:0] asserted
);

   if (STAGES < 1) begin : g_bad_stages
      $error("irqc_pin_sync: STAGES must be at least 1");
   end
   if (W < 1) begin : g_bad_w
      $error("irqc_pin_sync: W must be at least 1");
   end

   logic [W-1:0] st_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[0] <= '0;
      else        st_q[0] <= ~pins_n;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q[s] <= '0;
         else        st_q[s] <= st_q[s-1];
      end
   end

   assign asserted = st_q[STAGES-1];

endmodule

// File: rtl/irqc_nmi_edge.sv
module irqc_nmi_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_src,
   input  logic pin_src,
   output logic active,
   output logic pulse
);

   logic hist_q;

   assign active = soft_src | pin_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= active;
   end

   assign pulse = active & ~hist_q;

endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
   parameter int DATA_W      = 32,
   parameter int NUM_PINS    = 6,
   parameter int SEL_LSB     = 4,
   parameter int SEL_W       = 3,
   parameter int EN_LSB      = 16,
   parameter int TIMER_BIT   = 5,
   parameter bit TIMER_EN    = 1'b1,
   parameter int SYNC_STAGES = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sys_valid,
   input  logic                sys_cmd,
   input  logic                sys_wr,
   input  logic [DATA_W-1:0]   sys_data,
   input  logic [NUM_PINS-1:0] int_n,
   input  logic                nmi_n,
   input  logic                timer_eq,
   input  logic                timer_dis,
   input  logic [NUM_PINS-1:0] irq_mask,
   input  logic                irq_en,
   output logic [NUM_PINS-1:0] pending,
   output logic                irq_req,
   output logic                nmi_pulse
);

   localparam int REG_BITS = NUM_PINS + 1;
   localparam int NMI_BIT  = NUM_PINS;

   if (TIMER_BIT >= NUM_PINS) begin : g_bad_timer
      $error("irq_collector: TIMER_BIT outside pending vector");
   end
   if (EN_LSB + REG_BITS > DATA_W) begin : g_bad_en
      $error("irq_collector: enable field does not fit the bus");
   end

   logic                wr_stb;
   logic [REG_BITS-1:0] wr_mask;
   logic [REG_BITS-1:0] wr_val;
   logic [REG_BITS-1:0] int_reg_q;
   logic [NUM_PINS-1:0] pin_act;
   logic                nmi_pin_act;
   logic                nmi_active;

   irqc_bus_decode #(
      .DATA_W  (DATA_W),
      .SEL_LSB (SEL_LSB),
      .SEL_W   (SEL_W),
      .EN_LSB  (EN_LSB),
      .REG_BITS(REG_BITS)
   ) decode_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sys_valid(sys_valid),
      .sys_cmd  (sys_cmd),
      .sys_wr   (sys_wr),
      .sys_data (sys_data),
      .wr_stb   (wr_stb),
      .wr_mask  (wr_mask),
      .wr_val   (wr_val)
   );

   irqc_int_reg #(.REG_BITS(REG_BITS)) ireg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .wr_mask(wr_mask),
      .wr_val (wr_val),
      .q      (int_reg_q)
   );

   irqc_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) pins_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_n  (int_n),
      .asserted(pin_act)
   );

   irqc_pin_sync #(.W(1), .STAGES(SYNC_STAGES)) nmi_pin_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_n  (nmi_n),
      .asserted(nmi_pin_act)
   );

   irqc_nmi_edge nmi_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_src(int_reg_q[NMI_BIT]),
      .pin_src (nmi_pin_act),
      .active  (nmi_active),
      .pulse   (nmi_pulse)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pend
      if (TIMER_EN && i == TIMER_BIT) begin : g_timer_mux
         assign pending[i] = timer_dis ? (pin_act[i] | int_reg_q[i]) : timer_eq;
      end else begin : g_plain
         assign pending[i] = pin_act[i] | int_reg_q[i];
      end
   end

   if (!TIMER_EN) begin : g_no_timer
      logic timer_unused;
      assign timer_unused = timer_eq ^ timer_dis;
   end

   assign irq_req = irq_en & |(pending & irq_mask);

   logic nmi_active_unused;
   assign nmi_active_unused = nmi_active;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int DATA_W    = 32,
   parameter int NUM_PINS  = 6,
   parameter int EN_LSB    = 16,
   parameter int TIMER_BIT = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sys_valid,
   input logic                sys_cmd,
   input logic [DATA_W-1:0]   sys_data,
   input logic                timer_eq,
   input logic                timer_dis,
   input logic [NUM_PINS-1:0] irq_mask,
   input logic                irq_en,
   input logic [NUM_PINS-1:0] pending,
   input logic                irq_req,
   input logic                nmi_pulse,
   input logic [NUM_PINS:0]   int_reg_q
);

   localparam int REG_BITS = NUM_PINS + 1;

   AST_REG_NO_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(sys_valid && !sys_cmd) |=> $stable(int_reg_q)); // R3

   AST_REG_NO_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_valid && !sys_cmd && sys_data[EN_LSB +: REG_BITS] == '0) |=> $stable(int_reg_q)); // R2

   AST_TIMER_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !timer_dis |-> (pending[TIMER_BIT] == timer_eq)); // R5

   AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_en); // R6

   AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pending & irq_mask) == '0) |-> !irq_req); // R6

   AST_NMI_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse |=> !nmi_pulse); // R7

endmodule

bind irq_collector irqc_checker #(
   .DATA_W   (DATA_W),
   .NUM_PINS (NUM_PINS),
   .EN_LSB   (EN_LSB),
   .TIMER_BIT(TIMER_BIT)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .sys_valid(sys_valid),
   .sys_cmd  (sys_cmd),
   .sys_data (sys_data),
   .timer_eq (timer_eq),
   .timer_dis(timer_dis),
   .irq_mask (irq_mask),
   .irq_en   (irq_en),
   .pending  (pending),
   .irq_req  (irq_req),
   .nmi_pulse(nmi_pulse),
   .int_reg_q(int_reg_q)
);

// File: tb/irq_collector_tb_top.sv
module irq_collector_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_valid = 1'b0;
   logic        sys_cmd = 1'b0;
   logic        sys_wr = 1'b0;
   logic [31:0] sys_data = '0;
   logic [5:0]  int_n = '1;
   logic        nmi_n = 1'b1;
   logic        timer_eq = 1'b0;
   logic        timer_dis = 1'b1;
   logic [5:0]  irq_mask = '0;
   logic        irq_en = 1'b0;
   logic [5:0]  pending;
   logic        irq_req;
   logic        nmi_pulse;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   irq_collector dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sys_valid(sys_valid),
      .sys_cmd  (sys_cmd),
      .sys_wr   (sys_wr),
      .sys_data (sys_data),
      .int_n    (int_n),
      .nmi_n    (nmi_n),
      .timer_eq (timer_eq),
      .timer_dis(timer_dis),
      .irq_mask (irq_mask),
      .irq_en   (irq_en),
      .pending  (pending),
      .irq_req  (irq_req),
      .nmi_pulse(nmi_pulse)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #0.5;
   endtask

   // Address cycle then data cycle; returns after the data edge has passed
   task automatic bus_write(input logic [31:0] addr, input logic [6:0] en, input logic [6:0] val);
      @(negedge clk);
      sys_valid = 1'b1; sys_cmd = 1'b1; sys_wr = 1'b1; sys_data = addr;
      @(negedge clk);
      sys_cmd = 1'b0; sys_data = {9'd0, en, 9'd0, val};
      @(negedge clk);
      sys_valid = 1'b0; sys_wr = 1'b0; sys_data = '0;
      #0.5;
   endtask

   task automatic data_only(input logic [6:0] en, input logic [6:0] val);
      @(negedge clk);
      sys_valid = 1'b1; sys_cmd = 1'b0; sys_data = {9'd0, en, 9'd0, val};
      @(negedge clk);
      sys_valid = 1'b0; sys_data = '0;
      #0.5;
   endtask

   task automatic read_then_data(input logic [6:0] en, input logic [6:0] val);
      @(negedge clk);
      sys_valid = 1'b1; sys_cmd = 1'b1; sys_wr = 1'b0; sys_data = 32'h0;
      @(negedge clk);
      sys_cmd = 1'b0; sys_data = {9'd0, en, 9'd0, val};
      @(negedge clk);
      sys_valid = 1'b0; sys_data = '0;
      #0.5;
   endtask

   task automatic clear_reg();
      bus_write(32'h0, 7'h7F, 7'h00);
      tick();
   endtask

   task automatic t_reset();
      int_n = 6'b000000; nmi_n = 1'b0; irq_en = 1'b1; irq_mask = '1;
      repeat (3) tick();
      chk("R8", "pending in reset", {26'd0, pending}, 32'h0);
      chk("R8", "irq_req in reset", {31'd0, irq_req}, 32'h0);
      chk("R8", "nmi_pulse in reset", {31'd0, nmi_pulse}, 32'h0);
      int_n = '1; nmi_n = 1'b1; irq_en = 1'b0; irq_mask = '0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) tick();
   endtask

   task automatic t_decode();
      bus_write(32'hFFFF_FF8F, 7'h01, 7'h01);
      chk("R1", "select with high address bits", {26'd0, pending}, 32'h01);
      bus_write(32'h0000_0020, 7'h02, 7'h02);
      chk("R1", "non-selecting address", {26'd0, pending}, 32'h01);
      clear_reg();
   endtask

   task automatic t_enables();
      bus_write(32'h0, 7'h0F, 7'h0F);
      chk("R2", "set four bits", {26'd0, pending}, 32'h0F);
      bus_write(32'h0, 7'h06, 7'h79);
      chk("R2", "clear enabled only", {26'd0, pending}, 32'h09);
      clear_reg();
      chk("R2", "clear all", {26'd0, pending}, 32'h0);
   endtask

   task automatic t_orphan();
      data_only(7'h3F, 7'h3F);
      chk("R3", "orphan data cycle", {26'd0, pending}, 32'h0);
      read_then_data(7'h3F, 7'h3F);
      chk("R3", "data after read address", {26'd0, pending}, 32'h0);
   endtask

   task automatic t_pins();
      @(negedge clk);
      int_n = 6'b110101;
      #0.5;
      chk("R4", "before capture edge", {26'd0, pending}, 32'h0);
      tick();
      chk("R4", "after capture edge", {26'd0, pending}, 32'h0A);
      bus_write(32'h0, 7'h10, 7'h10);
      chk("R4", "pin OR register", {26'd0, pending}, 32'h1A);
      int_n = '1;
      tick();
      chk("R4", "pins released", {26'd0, pending}, 32'h10);
      clear_reg();
   endtask

   task automatic t_timer();
      @(negedge clk);
      timer_dis = 1'b0; timer_eq = 1'b1;
      #0.5;
      chk("R5", "timer selected high", {31'd0, pending[5]}, 32'h1);
      timer_eq = 1'b0; int_n = 6'b011111;
      tick(); tick();
      chk("R5", "pin ignored when timer selected", {31'd0, pending[5]}, 32'h0);
      timer_dis = 1'b1;
      #0.5;
      chk("R5", "pin used when timer disabled", {31'd0, pending[5]}, 32'h1);
      timer_eq = 1'b1; int_n = '1;
      tick();
      chk("R5", "timer ignored when disabled", {31'd0, pending[5]}, 32'h0);
      timer_eq = 1'b0;
   endtask

   task automatic t_mask();
      @(negedge clk);
      int_n = 6'b110101; irq_en = 1'b1; irq_mask = 6'b000010;
      tick();
      chk("R6", "masked-in source", {31'd0, irq_req}, 32'h1);
      irq_mask = 6'b000100;
      #0.5;
      chk("R6", "masked-out sources", {31'd0, irq_req}, 32'h0);
      irq_mask = '1; irq_en = 1'b0;
      #0.5;
      chk("R6", "global enable off", {31'd0, irq_req}, 32'h0);
      int_n = '1; irq_mask = '0;
      tick();
   endtask

   task automatic t_nmi_pin();
      @(negedge clk);
      nmi_n = 1'b0;
      tick();
      chk("R7", "pulse after falling pin", {31'd0, nmi_pulse}, 32'h1);
      tick();
      chk("R7", "pulse one cycle", {31'd0, nmi_pulse}, 32'h0);
      tick(); tick();
      chk("R7", "no pulse while held low", {31'd0, nmi_pulse}, 32'h0);
      nmi_n = 1'b1;
      tick(); tick();
      chk("R7", "no pulse on rising pin", {31'd0, nmi_pulse}, 32'h0);
      nmi_n = 1'b0;
      tick();
      chk("R7", "second falling edge pulses", {31'd0, nmi_pulse}, 32'h1);
      nmi_n = 1'b1;
      tick(); tick();
   endtask

   task automatic t_nmi_reg();
      bus_write(32'h0, 7'h40, 7'h40);
      chk("R9", "register bit 6 pulse", {31'd0, nmi_pulse}, 32'h1);
      chk("R9", "bit 6 not pending", {26'd0, pending}, 32'h0);
      tick();
      chk("R9", "register pulse one cycle", {31'd0, nmi_pulse}, 32'h0);
      nmi_n = 1'b0;
      tick();
      chk("R9", "pin masked by active bit 6", {31'd0, nmi_pulse}, 32'h0);
      nmi_n = 1'b1;
      clear_reg();
      tick();
   endtask

   initial begin
      t_reset();
      t_decode();
      t_enables();
      t_orphan();
      t_pins();
      t_timer();
      t_mask();
      t_nmi_pin();
      t_nmi_reg();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule